// File: doc/BRIEF.md
# Hourly Chime and Serial Melody Controller

This block runs the on-the-hour behaviour of a small digital clock with a 12 MHz system clock. It watches the minute and second digits. When they all turn to zero, it starts a buzzer alarm of bounded length and raises a one-cycle request asking a serial reporter to send the current temperature once. Note bytes from a serial receiver are queued and played one after another as square waves on the buzzer. While the melody lasts, a freeze output tells the display to stop updating the time and temperature.

A melody is sent as a plain character string at 9600 baud. Each character is one note code, so '!' (0x21) plays middle degree 1 and '%' (0x25) plays middle degree 5. A melody that starts during the alarm silences the alarm tone. Once the queue is empty, the last note has ended and the line has been quiet for the idle time, the freeze drops and the display runs live again.

Timing is set by parameters. `NOTE_CYC` is the length of one note (500 ms by default), `IDLE_CYC` is the quiet time before release (1 s), `ALARM_CYC` is the alarm length (30 s) and `TONE_SHIFT` scales the pitch table down (0 gives real pitches).

Top module: `hour_alarm_ctrl`

## Requirements
- R1: During and after reset, `buzzer`, `temp_req`, `freeze` and `alarm_on` are all low.
- R2: When the four digits `min_tens`, `min_ones`, `sec_tens` and `sec_ones` change from a value that is not all zero to all zero, `temp_req` is high for exactly one cycle, in the cycle after the change. `alarm_on` rises in that same cycle.
- R3: `alarm_on` stays high for exactly `ALARM_CYC` cycles. During those cycles the buzzer plays the middle degree 1 tone. After the alarm ends the buzzer is low.
- R4: Holding the digits at all zero gives no second request and no second alarm. Leaving reset while the digits are already zero does not fire either.
- R5: Digit changes between values that are not all zero never raise `temp_req` or `alarm_on`.
- R6: A note byte selects the octave with its upper nibble (0x1 low, 0x2 middle, 0x4 high) and the degree with its lower nibble (1 to 7). The buzzer period is the base count shifted right by `TONE_SHIFT`. The buzzer is high for floor(period/2) cycles at the start of each period. The base counts for degrees 1 to 7 are:
  - low octave: 45872, 40858, 36408, 34364, 30612, 27273, 24296
  - middle octave: 22931, 20432, 18201, 17180, 15306, 13636, 12148
  - high octave: 11478, 10215, 9101, 8590, 7653, 6818, 6074
- R7: Any other byte value occupies a note slot of the normal length, but the buzzer stays low for that slot.
- R8: `freeze` rises in the cycle after a byte arrives. It falls once three conditions all hold: the queue is empty, no note is playing, and `IDLE_CYC` cycles have passed since the last byte. While frozen with no note playing, the buzzer is low.
- R9: Each note plays for `NOTE_CYC` cycles. Queued notes follow each other with no gap, in arrival order.
- R10: The queue holds `FIFO_DEPTH` bytes, and a byte that arrives while it is full is dropped. A back-to-back burst of 20 bytes therefore plays `FIFO_DEPTH`+1 notes, because the first byte goes straight to the player.
- R11: A playback that starts during the alarm ends the alarm (`alarm_on` falls). The buzzer then follows the received notes.
- R12: A whole-hour event while frozen still pulses `temp_req`, but it does not start the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz by default) |
| rst_n | input | 1 | Asynchronous reset, active low |
| min_tens | input | 4 | Minute tens digit, BCD |
| min_ones | input | 4 | Minute ones digit, BCD |
| sec_tens | input | 4 | Second tens digit, BCD |
| sec_ones | input | 4 | Second ones digit, BCD |
| rx_data | input | 8 | Received note byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` valid |
| buzzer | output | 1 | Square-wave buzzer drive |
| temp_req | output | 1 | One-cycle request to send the temperature |
| freeze | output | 1 | Holds the display still during playback |
| alarm_on | output | 1 | High while the hourly alarm sounds |

## Verification
The properties assume that `rx_valid` is a single-cycle strobe, and that the time digits change only between clock edges and stay stable in between. The bench drives all inputs at the falling clock edge and sends each byte as a one-cycle pulse. Random stimulus is limited to valid BCD digit values and to octave/degree byte codes. The cases that matter for the timers, such as full-queue bursts, an alarm cut short by a melody, and an hour event during a freeze, are placed deliberately so that the expected note counts and freeze lengths can be worked out exactly.

// File: rtl/hac_pkg.sv
package hac_pkg;

  localparam int PER_W = 16;

  // Base half-cycle-free period, in system clock cycles, for a note code.
  // A code with no octave/degree meaning returns zero (silence).
  function automatic logic [PER_W-1:0] note_base(input logic [7:0] code);
    logic [PER_W-1:0] p;
    case (code)
      8'h11: p = 16'd45872;
      8'h12: p = 16'd40858;
      8'h13: p = 16'd36408;
      8'h14: p = 16'd34364;
      8'h15: p = 16'd30612;
      8'h16: p = 16'd27273;
      8'h17: p = 16'd24296;
      8'h21: p = 16'd22931;
      8'h22: p = 16'd20432;
      8'h23: p = 16'd18201;
      8'h24: p = 16'd17180;
      8'h25: p = 16'd15306;
      8'h26: p = 16'd13636;
      8'h27: p = 16'd12148;
      8'h41: p = 16'd11478;
      8'h42: p = 16'd10215;
      8'h43: p = 16'd9101;
      8'h44: p = 16'd8590;
      8'h45: p = 16'd7653;
      8'h46: p = 16'd6818;
      8'h47: p = 16'd6074;
      default: p = '0;
    endcase
    return p;
  endfunction

  // Period after the configurable pitch scaling.
  function automatic logic [PER_W-1:0] note_period(input logic [7:0] code, input int shift);
    return note_base(code) >> shift;
  endfunction

  // True when minutes and seconds are all zero.
  function automatic logic on_the_hour(input logic [3:0] mt, input logic [3:0] mo,
                                       input logic [3:0] st, input logic [3:0] so);
    return (mt == 4'd0) && (mo == 4'd0) && (st == 4'd0) && (so == 4'd0);
  endfunction

  localparam logic [7:0] ALARM_CODE = 8'h21;

endpackage

// File: rtl/hac_note_fifo.sv
module hac_note_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/hac_tone_gen.sv
module hac_tone_gen #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          wave
);

  logic [PW-1:0] per_q;
  logic [PW-1:0] cnt;
  logic          changed;
  logic          wrap;

  assign changed = (period != per_q);
  assign wrap    = (cnt == per_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt   <= '0;
    end else if (changed) begin
      per_q <= period;
      cnt   <= '0;
    end else if (per_q != '0) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // Quiet for the one cycle in which a new pitch is latched.
  assign wave = !changed && (per_q != '0) && (cnt < (per_q >> 1));

endmodule

// File: rtl/hac_hour_alarm.sv
module hac_hour_alarm
  import hac_pkg::*;
#(
  parameter int ALARM_CYC = 360_000_000,
  localparam int ACW      = $clog2(ALARM_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     min_tens,
  input  logic [3:0]     min_ones,
  input  logic [3:0]     sec_tens,
  input  logic [3:0]     sec_ones,
  input  logic           cancel,
  output logic           hour_evt,
  output logic           alarm_on,
  output logic           temp_req,
  output logic [ACW-1:0] alarm_cnt
);

  logic hour_now;
  logic hour_q;
  logic alarm_last;

  assign hour_now   = on_the_hour(min_tens, min_ones, sec_tens, sec_ones);
  assign hour_evt   = hour_now && !hour_q;
  assign alarm_last = (alarm_cnt == ACW'(ALARM_CYC - 1));

  // hour_q resets high so that a clock already at xx:00:00 does not fire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hour_q    <= 1'b1;
      temp_req  <= 1'b0;
      alarm_on  <= 1'b0;
      alarm_cnt <= '0;
    end else begin
      hour_q   <= hour_now;
      temp_req <= hour_evt;
      if (cancel) begin
        alarm_on  <= 1'b0;
        alarm_cnt <= '0;
      end else if (hour_evt) begin
        alarm_on  <= 1'b1;
        alarm_cnt <= '0;
      end else if (alarm_on) begin
        if (alarm_last) begin
          alarm_on  <= 1'b0;
          alarm_cnt <= '0;
        end else begin
          alarm_cnt <= alarm_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hac_playback.sv
module hac_playback #(
  parameter int NOTE_CYC = 6_000_000,
  parameter int IDLE_CYC = 12_000_000,
  localparam int NCW     = $clog2(NOTE_CYC + 1),
  localparam int ICW     = $clog2(IDLE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       q_empty,
  input  logic [7:0] q_head,
  output logic       q_pop,
  output logic       freeze,
  output logic       note_active,
  output logic [7:0] cur_code
);

  logic [NCW-1:0] note_cnt;
  logic [ICW-1:0] idle_cnt;
  logic           note_done;
  logic           idle_done;
  logic           load;

  assign note_done = note_active && (note_cnt == NCW'(NOTE_CYC - 1));
  assign idle_done = (idle_cnt == ICW'(IDLE_CYC - 1));
  assign load      = (!note_active || note_done) && !q_empty;
  assign q_pop     = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (rx_valid) begin
      idle_cnt <= '0;
    end else if (!idle_done) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_active <= 1'b0;
      note_cnt    <= '0;
      cur_code    <= '0;
    end else if (load) begin
      note_active <= 1'b1;
      note_cnt    <= '0;
      cur_code    <= q_head;
    end else if (note_done) begin
      note_active <= 1'b0;
      note_cnt    <= '0;
    end else if (note_active) begin
      note_cnt <= note_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze <= 1'b0;
    end else if (rx_valid) begin
      freeze <= 1'b1;
    end else if (freeze && !note_active && q_empty && idle_done) begin
      freeze <= 1'b0;
    end
  end

endmodule

// File: rtl/hour_alarm_ctrl.sv
module hour_alarm_ctrl
  import hac_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int NOTE_CYC   = 6_000_000,
  parameter int IDLE_CYC   = 12_000_000,
  parameter int ALARM_CYC  = 360_000_000,
  parameter int TONE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] min_tens,
  input  logic [3:0] min_ones,
  input  logic [3:0] sec_tens,
  input  logic [3:0] sec_ones,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       buzzer,
  output logic       temp_req,
  output logic       freeze,
  output logic       alarm_on
);

  localparam int ACW = $clog2(ALARM_CYC + 1);
  localparam int LW  = $clog2(FIFO_DEPTH + 1);

  logic             hour_evt;
  logic [ACW-1:0]   alarm_cnt;
  logic [7:0]       q_head;
  logic             q_empty, q_full, q_pop;
  logic [LW-1:0]    fifo_level;
  logic             note_active;
  logic [7:0]       cur_code;
  logic [PER_W-1:0] sel_period;

  hac_hour_alarm #(.ALARM_CYC(ALARM_CYC)) u_hour (
    .clk       (clk),
    .rst_n     (rst_n),
    .min_tens  (min_tens),
    .min_ones  (min_ones),
    .sec_tens  (sec_tens),
    .sec_ones  (sec_ones),
    .cancel    (freeze),
    .hour_evt  (hour_evt),
    .alarm_on  (alarm_on),
    .temp_req  (temp_req),
    .alarm_cnt (alarm_cnt)
  );

  hac_note_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_valid),
    .din   (rx_data),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .level (fifo_level)
  );

  hac_playback #(.NOTE_CYC(NOTE_CYC), .IDLE_CYC(IDLE_CYC)) u_play (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .q_empty     (q_empty),
    .q_head      (q_head),
    .q_pop       (q_pop),
    .freeze      (freeze),
    .note_active (note_active),
    .cur_code    (cur_code)
  );

  // Received notes win over the alarm; a frozen gap is silent.
  always_comb begin
    if (note_active)   sel_period = note_period(cur_code, TONE_SHIFT);
    else if (freeze)   sel_period = '0;
    else if (alarm_on) sel_period = note_period(ALARM_CODE, TONE_SHIFT);
    else               sel_period = '0;
  end

  hac_tone_gen #(.PW(PER_W)) u_tone (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (sel_period),
    .wave   (buzzer)
  );

endmodule

// File: rtl/hac_checker.sv
module hac_checker #(
  parameter int ALARM_CYC = 360_000_000,
  parameter int DEPTH     = 16,
  parameter int ACW       = 29,
  parameter int LW        = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hour_evt,
  input logic           temp_req,
  input logic           alarm_on,
  input logic [ACW-1:0] alarm_cnt,
  input logic           freeze,
  input logic           buzzer,
  input logic           note_active,
  input logic [LW-1:0]  fifo_level
);

  // R2: an hour event is followed by a request
  a_r2_req_follows_hour: assert property (@(posedge clk) disable iff (!rst_n)
    hour_evt |=> temp_req);

  // R4: request is a single-cycle pulse
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    temp_req |=> !temp_req);

  // R3: alarm counter never passes the limit
  a_r3_alarm_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_on |-> (alarm_cnt < ACW'(ALARM_CYC)));

  // R10: queue never overflows
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  // R11: notes and alarm never overlap
  a_r11_note_priority: assert property (@(posedge clk) disable iff (!rst_n)
    note_active |-> !alarm_on);

  // R8: a playing note always lies inside a freeze
  a_r8_note_in_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    note_active |-> freeze);

  // R8: no sound when neither alarm nor playback is active
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !alarm_on) |-> !buzzer);

endmodule

bind hour_alarm_ctrl hac_checker #(
  .ALARM_CYC (ALARM_CYC),
  .DEPTH     (FIFO_DEPTH),
  .ACW       (ACW),
  .LW        (LW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hour_evt    (hour_evt),
  .temp_req    (temp_req),
  .alarm_on    (alarm_on),
  .alarm_cnt   (alarm_cnt),
  .freeze      (freeze),
  .buzzer      (buzzer),
  .note_active (note_active),
  .fifo_level  (fifo_level)
);

// File: tb/sim_hour_alarm_ctrl.sv
`timescale 1ns/1ps
module sim_hour_alarm_ctrl;

  localparam int DEPTH = 16;
  localparam int NOTE  = 2000;
  localparam int IDLE  = 3000;
  localparam int ALARM = 5000;
  localparam int SHIFT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] min_tens = 0, min_ones = 0, sec_tens = 0, sec_ones = 0;
  logic [7:0] rx_data = 0;
  logic       rx_valid = 0;
  logic       buzzer, temp_req, freeze, alarm_on;

  int checks = 0, fails = 0;
  int cyc = 0;
  int req_cnt = 0, alarm_cycles = 0, freeze_cycles = 0;
  int base_tab [21];

  always #5 clk = ~clk;

  hour_alarm_ctrl #(
    .FIFO_DEPTH (DEPTH),
    .NOTE_CYC   (NOTE),
    .IDLE_CYC   (IDLE),
    .ALARM_CYC  (ALARM),
    .TONE_SHIFT (SHIFT)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .buzzer(buzzer), .temp_req(temp_req), .freeze(freeze), .alarm_on(alarm_on)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (temp_req) req_cnt++;
    if (alarm_on) alarm_cycles++;
    if (freeze) freeze_cycles++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input logic [7:0] b);
    int row, deg;
    case (b[7:4])
      4'h1: row = 0;
      4'h2: row = 1;
      4'h4: row = 2;
      default: row = -1;
    endcase
    deg = int'(b[3:0]);
    if (row < 0 || deg < 1 || deg > 7) return 0;
    return base_tab[row * 7 + deg - 1] / (1 << SHIFT);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_time(input int mt, input int mo, input int st, input int so);
    min_tens = 4'(mt); min_ones = 4'(mo); sec_tens = 4'(st); sec_ones = 4'(so);
  endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic measure(output int per, output int hi);
    int guard;
    logic last;
    guard = 0; per = 0; hi = 0;
    while (buzzer && guard < 4000) begin @(negedge clk); guard++; end
    while (!buzzer && guard < 4000) begin @(negedge clk); guard++; end
    while (guard < 4000) begin
      if (buzzer) hi++;
      per++;
      last = buzzer;
      @(negedge clk); guard++;
      if (buzzer && !last) break;
    end
  endtask

  task automatic wait_release();
    int g;
    g = 0;
    while (freeze && g < 60000) begin @(negedge clk); g++; end
    tick(2);
  endtask

  task automatic hour_step();
    set_time(5, 9, 5, 9);
    tick(3);
    set_time(0, 0, 0, 0);
  endtask

  // Watchdog
  initial begin
    tick(150000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int per, hi, r0, a0, t0, hcount;
    logic [7:0] b;
    base_tab = '{45872, 40858, 36408, 34364, 30612, 27273, 24296,
                 22931, 20432, 18201, 17180, 15306, 13636, 12148,
                 11478, 10215, 9101, 8590, 7653, 6818, 6074};
    void'($urandom(32'd4242));

    // R1 / R4: reset with the clock already at the whole hour
    set_time(0, 0, 0, 0);
    tick(4);
    chk(!buzzer && !temp_req && !freeze && !alarm_on, "R1 in reset", int'(buzzer | temp_req | freeze | alarm_on), 0);
    rst_n = 1'b1;
    tick(10);
    chk(!buzzer && !temp_req && !freeze && !alarm_on, "R1 after reset", int'(buzzer | temp_req | freeze | alarm_on), 0);
    chk(req_cnt == 0, "R4 no fire from reset", req_cnt, 0);

    // R5: random non-hour times
    set_time(3, 4, 1, 2);
    tick(3);
    r0 = req_cnt;
    for (int i = 0; i < 40; i++) begin
      int mt, mo, st, so;
      mt = $urandom_range(5); mo = $urandom_range(9);
      st = $urandom_range(5); so = $urandom_range(9);
      if (mt == 0 && mo == 0 && st == 0 && so == 0) so = 1;
      set_time(mt, mo, st, so);
      tick(2);
    end
    chk(req_cnt == r0 && !alarm_on, "R5 no event off the hour", req_cnt - r0, 0);

    // R2: hour rollover
    set_time(5, 9, 5, 9);
    tick(3);
    alarm_cycles = 0;
    r0 = req_cnt;
    set_time(0, 0, 0, 0);
    tick(1);
    chk(temp_req == 1'b1, "R2 request in cycle after rollover", int'(temp_req), 1);
    chk(alarm_on == 1'b1, "R2 alarm starts with request", int'(alarm_on), 1);
    tick(1);
    chk(temp_req == 1'b0, "R2 request one cycle", int'(temp_req), 0);

    // R3: alarm tone and length
    measure(per, hi);
    chk(per == exp_period(8'h21), "R3 alarm tone period", per, exp_period(8'h21));
    while (alarm_on && cyc < 140000) tick(1);
    tick(2);
    chk(alarm_cycles == ALARM, "R3 alarm length", alarm_cycles, ALARM);
    chk(!buzzer, "R3 buzzer low after alarm", int'(buzzer), 0);
    // R4: held at the hour, one request only
    chk(req_cnt - r0 == 1, "R4 single request while held", req_cnt - r0, 1);

    // R6: random valid notes
    for (int i = 0; i < 6; i++) begin
      int oi;
      oi = $urandom_range(2);
      b = {(oi == 0) ? 4'h1 : (oi == 1) ? 4'h2 : 4'h4, 4'($urandom_range(7, 1))};
      send(b);
      measure(per, hi);
      chk(per == exp_period(b), $sformatf("R6 period code %02h", b), per, exp_period(b));
      chk(hi == exp_period(b) / 2, $sformatf("R6 high time code %02h", b), hi, exp_period(b) / 2);
      wait_release();
    end

    // R7: invalid code is silent but freezes
    send(8'h38);
    tick(5);
    hcount = 0;
    for (int i = 0; i < 1500; i++) begin
      if (buzzer) hcount++;
      @(negedge clk);
    end
    chk(hcount == 0, "R7 invalid code silent", hcount, 0);
    chk(freeze == 1'b1, "R7 freeze held on invalid code", int'(freeze), 1);
    wait_release();

    // R8: single byte, release after the idle time
    freeze_cycles = 0;
    send(8'h25);
    chk(freeze == 1'b1, "R8 freeze rises after byte", int'(freeze), 1);
    wait_release();
    chk(freeze_cycles >= IDLE - 3 && freeze_cycles <= IDLE + 1, "R8 release after idle", freeze_cycles, IDLE - 1);
    chk(!buzzer, "R8 buzzer low after release", int'(buzzer), 0);

    // R9: three back-to-back notes
    freeze_cycles = 0;
    t0 = cyc;
    send(8'h21); send(8'h25); send(8'h47);
    measure(per, hi);
    chk(per == exp_period(8'h21), "R9 first note", per, exp_period(8'h21));
    while (cyc < t0 + NOTE + 200) tick(1);
    measure(per, hi);
    chk(per == exp_period(8'h25), "R9 second note", per, exp_period(8'h25));
    while (cyc < t0 + 2 * NOTE + 200) tick(1);
    measure(per, hi);
    chk(per == exp_period(8'h47), "R9 third note", per, exp_period(8'h47));
    wait_release();
    chk(freeze_cycles >= 3 * NOTE && freeze_cycles <= 3 * NOTE + 4, "R9 note lengths", freeze_cycles, 3 * NOTE + 2);

    // R10: burst of 20 bytes into a 16-deep queue
    freeze_cycles = 0;
    for (int i = 0; i < 20; i++) send(8'h41 + 8'(i % 7));
    wait_release();
    chk(freeze_cycles >= (DEPTH + 1) * NOTE && freeze_cycles <= (DEPTH + 1) * NOTE + 4,
        "R10 overflow bytes dropped", freeze_cycles, (DEPTH + 1) * NOTE + 2);

    // R11: playback cancels a running alarm
    hour_step();
    tick(50);
    chk(alarm_on == 1'b1, "R11 alarm running", int'(alarm_on), 1);
    a0 = alarm_cycles;
    send(8'h45);
    tick(3);
    chk(alarm_on == 1'b0, "R11 alarm cancelled", int'(alarm_on), 0);
    measure(per, hi);
    chk(per == exp_period(8'h45), "R11 note replaces alarm tone", per, exp_period(8'h45));

    // R12: hour during freeze requests but does not alarm
    r0 = req_cnt;
    a0 = alarm_cycles;
    hour_step();
    tick(4);
    chk(req_cnt - r0 == 1, "R12 request during freeze", req_cnt - r0, 1);
    chk(alarm_cycles == a0, "R12 no alarm during freeze", alarm_cycles - a0, 0);
    wait_release();
    chk(!alarm_on && !buzzer, "R12 silent after release", int'(alarm_on | buzzer), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule